// File: doc/BRIEF.md
# Shared Secret Buffer Access Arbiter

Several hardware threads share a single off-core staging buffer through which
random-number, random-seed and key-derivation results reach the core. Such a
read is protected unless the thread has opted out: the thread becomes the sole
owner of the buffer. While it owns the buffer, cache-miss traffic from every
other thread is held back. When the read finishes, the buffer is cleared to
zero before any other thread may claim it. Protected reads that arrive together
are served one at a time, in round-robin order.

Each thread has a private control register. Its lowest bit lets the thread
skip protection for random-number and random-seed reads made outside a secure
enclave. A thread that skips protection gets its grant in the same cycle. It
does not lock the buffer and does not stall its siblings. The skip bit has no
effect in enclave mode or on key-derivation reads.

Top module: `secret_buf_arbiter`

## Requirements
- R1: After reset, no grant or stall is asserted, the staging buffer holds zero, and every thread's opt-out bit reads back as 0.
- R2: A protected read is granted to exactly one owner starting the cycle after it is chosen. The grant is held until `rdDone` is seen. The buffer is then forced to zero for SCRUB_CYCLES cycles, during which `fillEn` is ignored.
- R3: While the buffer is locked (owned or being scrubbed), `missStall[j]` equals `missReq[j]` for every thread j other than the owner. The owner and threads with no pending miss are never stalled. When the buffer is not locked, nothing is stalled.
- R4: Pending protected requests are served round-robin, starting from thread 0 after reset. The owner does not change while its grant is held.
- R5: Each thread's control register sits at address 0x123. A write with `cfgWe` at that address stores `cfgWdata[0]` as the thread's opt-out bit. Reads of that address return the bit in bit 0 and zeros in bits 31:1. Writes and reads at any other address have no effect and return 0.
- R6: A read type field of 2'b00 means random number, 2'b01 random seed, 2'b10 key derivation, and 2'b11 is handled like key derivation. Suppose a thread has opt-out set, is not in enclave mode, and requests type 2'b00 or 2'b01. Its grant then follows `rdReq` in the same cycle, and the read neither locks the buffer nor stalls any sibling.
- R7: A set opt-out bit is overridden, and the read is protected, when the requester's `enclaveMode` is 1 or its read type is 2'b10 or 2'b11.
- R8: One thread's opt-out bit changes only how that thread's own reads are handled.
- R9: `ctrlPresent` is always 1.
- R10: After a protected read completes, no new protected grant appears until the scrub has finished and one idle cycle has passed. A back-to-back handover therefore leaves SCRUB_CYCLES+1 cycles without a protected grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdReq | input | NUM_THREADS | Special-read request per thread |
| rdType | input | 2*NUM_THREADS | Read type per thread, 2 bits each (see R6) |
| enclaveMode | input | NUM_THREADS | Thread executes inside a secure enclave |
| rdDone | input | 1 | Current protected read has completed |
| rdGrant | output | NUM_THREADS | Special-read grant per thread |
| missReq | input | NUM_THREADS | Off-core access that missed the core caches |
| missStall | output | NUM_THREADS | Hold off that thread's off-core access |
| fillEn | input | 1 | Entropy/key source writes the staging buffer |
| fillData | input | DATA_W | Data written into the staging buffer |
| bufData | output | DATA_W | Staging buffer contents |
| cfgWe | input | 1 | Control register write strobe |
| cfgThread | input | TW | Thread whose control register is accessed |
| cfgAddr | input | ADDR_W | Register address |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data |
| ctrlPresent | output | 1 | Presence indication of the control register |

## Verification
Two events can fall in the same cycle. The first is an opted-out thread getting its immediate grant while another thread owns the locked buffer. The second is a buffer fill arriving in a cycle when the scrub is active. The random phase produces both: it drives requests, read types, enclave flags, fills and opt-out writes freely together, with `rdDone` asserted at random. A cycle-level reference model in the bench judges every grant, stall, buffer value and readback. It checks that the unprotected grant neither disturbs the owner nor adds stalls, and that the scrub wins over the fill.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    RD_RAND = 2'b00,
    RD_SEED = 2'b01,
    RD_KEY  = 2'b10,
    RD_RSVD = 2'b11
  } rdKind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_SCRUB = 2'd2
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic scrub;
    logic lock;
  } ctlStrobe_t;

  localparam logic [11:0] CTRL_REG_ADDR = 12'h123;
endpackage

// File: rtl/sba_control.sv
module sba_control
  import sba_pkg::*;
#(
  parameter int N            = 4,
  parameter int SCRUB_CYCLES = 2,
  parameter int TW           = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] protReq,
  input  logic         rdDone,
  output ctlStrobe_t   strobe,
  output logic [N-1:0] ownerOh,
  output logic [N-1:0] ownerGrant
);
  localparam int CW = (SCRUB_CYCLES > 1) ? $clog2(SCRUB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SCRUB_CYCLES - 1);

  arbState_t state;
  logic [TW-1:0] owner, rrPtr, pickIdx;
  logic [CW-1:0] scrubCnt;
  logic found;

  always_comb begin
    found = 1'b0;
    pickIdx = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && protReq[(int'(rrPtr) + k) % N]) begin
        found = 1'b1;
        pickIdx = TW'((int'(rrPtr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      owner    <= '0;
      rrPtr    <= '0;
      scrubCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (found) begin
          state <= ST_BUSY;
          owner <= pickIdx;
          rrPtr <= TW'((int'(pickIdx) + 1) % N);
        end
        ST_BUSY: if (rdDone) begin
          state    <= ST_SCRUB;
          scrubCnt <= '0;
        end
        ST_SCRUB: begin
          if (scrubCnt == CNT_LAST) state <= ST_IDLE;
          else scrubCnt <= scrubCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.lock  = (state != ST_IDLE);
    strobe.scrub = (state == ST_SCRUB);
    ownerOh = '0;
    if (strobe.lock) ownerOh[owner] = 1'b1;
    ownerGrant = (state == ST_BUSY) ? ownerOh : '0;
  end
endmodule

// File: rtl/sba_datapath.sv
module sba_datapath
  import sba_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int TW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [N-1:0]      ownerOh,
  input  logic [N-1:0]      rdReq,
  input  logic [2*N-1:0]    rdType,
  input  logic [N-1:0]      enclaveMode,
  input  logic [N-1:0]      missReq,
  input  logic              fillEn,
  input  logic [DATA_W-1:0] fillData,
  input  logic              cfgWe,
  input  logic [TW-1:0]     cfgThread,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [N-1:0]      protReq,
  output logic [N-1:0]      missStall,
  output logic [DATA_W-1:0] bufData,
  output logic [31:0]       cfgRdata
);
  logic [N-1:0] optOut;
  logic addrHit;

  assign addrHit = (cfgAddr == ADDR_W'(CTRL_REG_ADDR));

  for (genvar i = 0; i < N; i++) begin : g_thr
    rdKind_t kind;
    assign kind = rdKind_t'(rdType[2*i +: 2]);
    assign protReq[i] = rdReq[i] &
      ((kind == RD_KEY) | (kind == RD_RSVD) | enclaveMode[i] | ~optOut[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) optOut[i] <= 1'b0;
      else if (cfgWe && addrHit && (int'(cfgThread) == i)) optOut[i] <= cfgWdata[0];
    end
  end

  assign missStall = missReq & ~ownerOh & {N{strobe.lock}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bufData <= '0;
    else if (strobe.scrub) bufData <= '0;
    else if (fillEn) bufData <= fillData;
  end

  always_comb begin
    cfgRdata = '0;
    if (addrHit) cfgRdata[0] = optOut[cfgThread];
  end
endmodule

// File: rtl/secret_buf_arbiter.sv
module secret_buf_arbiter
  import sba_pkg::*;
#(
  parameter int NUM_THREADS  = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 12,
  parameter int SCRUB_CYCLES = 2,
  parameter int TW           = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_THREADS-1:0]   rdReq,
  input  logic [2*NUM_THREADS-1:0] rdType,
  input  logic [NUM_THREADS-1:0]   enclaveMode,
  input  logic                     rdDone,
  output logic [NUM_THREADS-1:0]   rdGrant,
  input  logic [NUM_THREADS-1:0]   missReq,
  output logic [NUM_THREADS-1:0]   missStall,
  input  logic                     fillEn,
  input  logic [DATA_W-1:0]        fillData,
  output logic [DATA_W-1:0]        bufData,
  input  logic                     cfgWe,
  input  logic [TW-1:0]            cfgThread,
  input  logic [ADDR_W-1:0]        cfgAddr,
  input  logic [31:0]              cfgWdata,
  output logic [31:0]              cfgRdata,
  output logic                     ctrlPresent
);
  ctlStrobe_t ctlStb;
  logic [NUM_THREADS-1:0] protReq, ownerOh, ownerGrant;

  sba_control #(.N(NUM_THREADS), .SCRUB_CYCLES(SCRUB_CYCLES), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .protReq(protReq), .rdDone(rdDone),
    .strobe(ctlStb), .ownerOh(ownerOh), .ownerGrant(ownerGrant)
  );

  sba_datapath #(.N(NUM_THREADS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TW(TW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(ctlStb), .ownerOh(ownerOh),
    .rdReq(rdReq), .rdType(rdType), .enclaveMode(enclaveMode),
    .missReq(missReq), .fillEn(fillEn), .fillData(fillData),
    .cfgWe(cfgWe), .cfgThread(cfgThread), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .protReq(protReq), .missStall(missStall), .bufData(bufData), .cfgRdata(cfgRdata)
  );

  assign rdGrant     = ownerGrant | (rdReq & ~protReq);
  assign ctrlPresent = 1'b1;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int N      = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock,
  input logic [N-1:0]      ownerOh,
  input logic [N-1:0]      ownerGrant,
  input logic [N-1:0]      missReq,
  input logic [N-1:0]      missStall,
  input logic [DATA_W-1:0] bufData
);
  logic busy;
  assign busy = |ownerGrant;

  p_scrubbed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> (bufData == '0));

  p_miss_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (missStall & ~missReq) == '0);

  p_idle_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (missStall == '0));

  p_owner_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (missStall & ownerOh) == '0);

  p_owner_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ownerGrant));

  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!lock));
endmodule

bind secret_buf_arbiter sba_checker #(.N(NUM_THREADS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(ctlStb.lock), .ownerOh(ownerOh),
  .ownerGrant(ownerGrant), .missReq(missReq), .missStall(missStall),
  .bufData(bufData)
);

// File: tb/secret_buf_arbiter_test.sv
module secret_buf_arbiter_test;
  localparam int N = 4;
  localparam int DW = 32;
  localparam int SC = 2;
  localparam logic [11:0] REG_A = 12'h123;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rdReq = '0, enclaveMode = '0, missReq = '0;
  logic [2*N-1:0] rdType = '0;
  logic rdDone = 1'b0, fillEn = 1'b0, cfgWe = 1'b0;
  logic [DW-1:0] fillData = '0;
  logic [1:0] cfgThread = '0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [N-1:0] rdGrant, missStall;
  logic [DW-1:0] bufData;
  logic [31:0] cfgRdata;
  logic ctrlPresent;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  int mState = 0, mOwner = 0, mPtr = 0, mCnt = 0;
  logic [N-1:0] mOpt = '0;
  logic [DW-1:0] mBuf = '0;

  always #5 clk = ~clk;

  secret_buf_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rdReq(rdReq), .rdType(rdType),
    .enclaveMode(enclaveMode), .rdDone(rdDone), .rdGrant(rdGrant),
    .missReq(missReq), .missStall(missStall), .fillEn(fillEn),
    .fillData(fillData), .bufData(bufData), .cfgWe(cfgWe),
    .cfgThread(cfgThread), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .ctrlPresent(ctrlPresent)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit isProt(input int i);
    return (rdType[2*i+1] == 1'b1) || enclaveMode[i] || !mOpt[i];
  endfunction

  function automatic logic [N-1:0] expGrant();
    logic [N-1:0] g = '0;
    for (int i = 0; i < N; i++)
      g[i] = (mState == 1 && mOwner == i) || (rdReq[i] && !isProt(i));
    return g;
  endfunction

  function automatic logic [N-1:0] expStall();
    logic [N-1:0] s = '0;
    for (int i = 0; i < N; i++)
      s[i] = missReq[i] && (mState != 0) && (mOwner != i);
    return s;
  endfunction

  function automatic logic [31:0] expRd();
    return (cfgAddr == REG_A) ? {31'b0, mOpt[cfgThread]} : 32'b0;
  endfunction

  // one clock: check outputs mid-cycle, then advance model with the edge
  task automatic cycle();
    #2;
    chk(rdGrant == expGrant(), "R2/R6", "rdGrant", 32'(rdGrant), 32'(expGrant()));
    chk(missStall == expStall(), "R3", "missStall", 32'(missStall), 32'(expStall()));
    chk(bufData == mBuf, "R2", "bufData", bufData, mBuf);
    chk(cfgRdata == expRd(), "R5", "cfgRdata", cfgRdata, expRd());
    @(posedge clk);
    begin
      int nState = mState, nOwner = mOwner, nPtr = mPtr, nCnt = mCnt;
      bit got = 0;
      if (mState == 0) begin
        for (int k = 0; k < N; k++) begin
          int j = (mPtr + k) % N;
          if (!got && rdReq[j] && isProt(j)) begin
            got = 1; nState = 1; nOwner = j; nPtr = (j + 1) % N;
          end
        end
      end else if (mState == 1) begin
        if (rdDone) begin nState = 2; nCnt = 0; end
      end else begin
        if (mCnt == SC - 1) nState = 0; else nCnt = mCnt + 1;
      end
      if (mState == 2) mBuf = '0; else if (fillEn) mBuf = fillData;
      if (cfgWe && cfgAddr == REG_A) mOpt[cfgThread] = cfgWdata[0];
      mState = nState; mOwner = nOwner; mPtr = nPtr; mCnt = nCnt;
    end
    @(negedge clk);
  endtask

  task automatic writeOpt(input int thr, input logic [31:0] val, input logic [11:0] a);
    cfgWe = 1'b1; cfgThread = 2'(thr); cfgAddr = a; cfgWdata = val;
    cycle();
    cfgWe = 1'b0; cfgAddr = REG_A;
  endtask

  task automatic drain();
    rdReq = '0; missReq = '0; enclaveMode = '0; rdType = '0; fillEn = 1'b0;
    rdDone = 1'b1;
    repeat (SC + 3) cycle();
    rdDone = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cfgAddr = REG_A;
    repeat (3) @(negedge clk);
    // R1: reset state
    #2;
    chk(rdGrant == '0 && missStall == '0, "R1", "grant/stall in reset", 32'({rdGrant, missStall}), 0);
    chk(bufData == '0, "R1", "buffer in reset", bufData, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < N; t++) begin
      cfgThread = 2'(t); #1;
      chk(cfgRdata == 32'd0, "R1", "opt-out reset", cfgRdata, 0);
    end
    chk(ctrlPresent == 1'b1, "R9", "presence", 32'(ctrlPresent), 1);
    @(negedge clk);

    // R5: register write/readback, upper bits zero, other address ignored
    writeOpt(1, 32'hFFFF_FFFF, REG_A);
    cfgThread = 2'd1; #1;
    chk(cfgRdata == 32'd1, "R5", "readback bit0 only", cfgRdata, 1);
    @(negedge clk);
    writeOpt(1, 32'h0, 12'h124);
    cfgThread = 2'd1; cfgAddr = REG_A; #1;
    chk(cfgRdata == 32'd1, "R5", "other address ignored", cfgRdata, 1);
    cfgAddr = 12'h124; #1;
    chk(cfgRdata == 32'd0, "R5", "other address reads 0", cfgRdata, 0);
    cfgAddr = REG_A;
    @(negedge clk);

    // R6/R8: thread1 opted out (random), thread2 protected (random)
    fillEn = 1'b1; fillData = 32'hCAFE_0001; cycle(); fillEn = 1'b0;
    rdReq = 4'b0010; rdType = 8'b00_00_00_00; missReq = 4'b0001;
    #2;
    chk(rdGrant == 4'b0010, "R6", "same-cycle unprotected grant", 32'(rdGrant), 32'h2);
    chk(missStall == 4'b0000, "R6", "no sibling stall", 32'(missStall), 0);
    cycle();
    chk(rdGrant == 4'b0010 && missStall == 4'b0000, "R6", "no lock after edge", 32'({rdGrant, missStall}), 32'h20);
    rdReq = 4'b0110; cycle();
    chk(rdGrant == 4'b0110, "R8", "thread2 protected despite thread1 opt-out", 32'(rdGrant), 32'h6);
    chk(missStall == 4'b0001, "R3", "thread0 miss stalled", 32'(missStall), 32'h1);
    drain();
    chk(bufData == '0, "R2", "buffer scrubbed", bufData, 0);

    // R7: enclave overrides opt-out
    rdReq = 4'b0010; enclaveMode = 4'b0010; missReq = 4'b1001;
    #2;
    chk(rdGrant == 4'b0000, "R7", "enclave read waits for lock", 32'(rdGrant), 0);
    cycle();
    chk(rdGrant == 4'b0010 && missStall == 4'b1001, "R7", "enclave read locks", 32'({rdGrant, missStall}), 32'h29);
    drain();
    // R7: key read overrides opt-out
    rdReq = 4'b0010; rdType = 8'b00_00_10_00;
    #2;
    chk(rdGrant == 4'b0000, "R7", "key read not immediate", 32'(rdGrant), 0);
    cycle();
    chk(rdGrant == 4'b0010, "R7", "key read granted under lock", 32'(rdGrant), 32'h2);
    drain();

    // R4/R10: round robin and scrub gap (pointer is at 2 after thread1)
    rdReq = 4'b1101; rdType = '0; cycle();
    chk(rdGrant == 4'b0100, "R4", "round-robin first", 32'(rdGrant), 32'h4);
    rdDone = 1'b1; cycle(); rdDone = 1'b0; rdReq[2] = 1'b0;
    for (int g = 0; g < SC; g++) begin
      chk(rdGrant == 4'b0000, "R10", "no grant during scrub", 32'(rdGrant), 0);
      cycle();
    end
    chk(rdGrant == 4'b0000, "R10", "idle cycle after scrub", 32'(rdGrant), 0);
    cycle();
    chk(rdGrant == 4'b1000, "R4", "round-robin second", 32'(rdGrant), 32'h8);
    rdDone = 1'b1; cycle(); rdDone = 1'b0; rdReq[3] = 1'b0;
    repeat (SC + 1) cycle();
    chk(rdGrant == 4'b0001, "R4", "round-robin wrap", 32'(rdGrant), 32'h1);
    drain();

    // random phase, checked by the model every cycle (R2, R3, R6, R7 together)
    for (int n = 0; n < 3000; n++) begin
      rdReq = 4'($urandom());
      rdType = 8'($urandom());
      enclaveMode = 4'($urandom() & $urandom());
      missReq = 4'($urandom());
      rdDone = ($urandom() % 4) == 0;
      fillEn = ($urandom() % 2) == 0;
      fillData = $urandom();
      cfgThread = 2'($urandom());
      cfgAddr = (($urandom() % 4) == 0) ? 12'h124 : REG_A;
      cfgWe = ($urandom() % 8) == 0;
      cfgWdata = $urandom();
      cycle();
    end
    cfgWe = 1'b0;
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule